// File: doc/BRIEF.md
# Bit-Serial HDLC Transmit Framer with Inter-Frame Fill Control

This block turns a stream of tagged bytes into a bit-serial HDLC-style line signal. It reads bytes from a show-ahead transmit FIFO. Each byte carries an end-of-packet tag and an abort tag. The block sends each frame as an opening flag, then the payload least significant bit first, then a 16-bit frame check sequence and a closing flag. Zero-bit insertion is applied to the payload and the check sequence. One serial bit leaves the block for each strobe on the bit-enable input. Between strobes the output holds.

Between frames the line carries a fill pattern, chosen by a 2-bit select: flags, idle ones or go-ahead patterns. Two events end a frame early. An underrun happens when the FIFO runs dry in the middle of a frame. An abort happens when an abort-tagged byte reaches the FIFO head. In both cases the block sends eight ones in place of the byte. It then falls back to fill, or starts the next frame. While go-ahead fill is selected, no new frame starts, even when data is waiting. Clearing the enable input forces the line to idle ones at once and drops any frame in progress.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is asserted, and right after it, `tx_bit` is 1 and `fifo_pop` is 0.
- R2: `tx_bit` changes only on the clock edge that samples `bit_en` high. It holds its value on every other edge.
- R3: With the FIFO empty, fill bytes go out least significant bit first, back to back. The fill select encoding is 00 for 7E hex (flags), 01 for FF hex (idle ones), 10 for 7F hex (go-ahead), and 11 for 7E hex.
- R4: A frame starts at a byte boundary when the FIFO is not empty and the fill select is not 10. The frame is the flag 7E hex, then each popped byte least significant bit first. `fifo_pop` pulses once in the bit-enable cycle where a byte is taken.
- R5: In the payload and the check sequence, a 0 is inserted after every run of five 1s, including a run that ends at a byte boundary. Flags, aborts and fill are sent without insertion.
- R6: After the byte tagged end-of-packet, the block sends the one's complement of CRC-16-CCITT, least significant bit first. The CRC uses the reflected polynomial 8408 hex, is preset to FFFF hex, and covers the payload bytes. A closing flag 7E hex follows.
- R7: If the FIFO is empty when the next byte of an unfinished frame is due, the block sends eight 1s and then returns to the selected fill.
- R8: An abort-tagged byte is popped but not sent. Eight 1s are sent in its place. After that, normal operation resumes: fill, or a new frame when data is waiting.
- R9: While the fill select is 10, only go-ahead bytes are sent between frames, and no byte is popped. Once the select changes, a waiting frame starts at the next byte boundary.
- R10: A bit-enable strobe with `tx_enable` low sends a 1 and pops nothing. Bytes still in the FIFO stay there.
- R11: `fifo_pop` is never asserted while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_enable | input | 1 | Transmitter enable; low forces idle ones |
| fill_sel | input | 2 | Inter-frame fill select (00 flag, 01 ones, 10 go-ahead, 11 flag) |
| bit_en | input | 1 | One-cycle strobe, one serial bit per strobe |
| fifo_data | input | 8 | Byte at the FIFO head (show-ahead) |
| fifo_eop | input | 1 | Head byte closes the packet |
| fifo_abort | input | 1 | Head byte requests a frame abort |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_pop | output | 1 | Consume the head byte this cycle |
| tx_bit | output | 1 | Serial line bit |

## Verification
The bit for a strobe is registered on the edge that samples `bit_en` high. It is due at the falling edge after that edge and holds until the next strobe. `fifo_pop` is combinational, and the bench FIFO acts on it in the same strobe cycle. The bench builds the expected line bits for each scenario into a queue. For this it uses its own byte-wise CRC and its own bit-stuffing model. A monitor records whether the strobe was high at each rising edge, and at the next falling edge it takes the next expected bit and compares it with `tx_bit`. On every cycle without a strobe, the monitor checks instead that `tx_bit` kept its last value.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  localparam logic [BYTE_W-1:0] PAT_FLAG  = 8'h7E;
  localparam logic [BYTE_W-1:0] PAT_ONES  = 8'hFF;
  localparam logic [BYTE_W-1:0] PAT_GOAHD = 8'h7F;

  localparam logic [1:0] FILL_FLAG  = 2'b00;
  localparam logic [1:0] FILL_IDLE  = 2'b01;
  localparam logic [1:0] FILL_GOAHD = 2'b10;

  typedef enum logic [2:0] {
    ST_FILL, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT
  } tx_state_e;

  // Pattern sent between frames for a given fill select.
  function automatic logic [BYTE_W-1:0] fill_pattern(input logic [1:0] sel);
    case (sel)
      FILL_IDLE:  return PAT_ONES;
      FILL_GOAHD: return PAT_GOAHD;
      default:    return PAT_FLAG;
    endcase
  endfunction

  // One serial step of a reflected CRC.
  function automatic logic [CRC_W-1:0] crc_bit_step(input logic [CRC_W-1:0] c,
                                                    input logic b,
                                                    input logic [CRC_W-1:0] poly);
    logic fb;
    fb = c[0] ^ b;
    return fb ? ((c >> 1) ^ poly) : (c >> 1);
  endfunction
endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
  import hdlc_tx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             shift,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '1;
    else if (init)  crc_q <= '1;
    else if (shift) crc_q <= crc_bit_step(crc_q, din, POLY);
  end

  AST_PRESET_ON_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (crc_q == '1)); // R6
endmodule

// File: rtl/hdlc_zero_stuffer.sv
module hdlc_zero_stuffer #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic advance,
  input  logic bit_val,
  input  logic stuff_take,
  output logic stuff_req
);
  localparam int ONES_W = $clog2(RUN + 1);

  logic [ONES_W-1:0] ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ones_q <= '0;
    else if (clear)      ones_q <= '0;
    else if (stuff_take) ones_q <= '0;
    else if (advance)    ones_q <= bit_val ? ones_q + 1'b1 : '0;
  end

  assign stuff_req = (ones_q == ONES_W'(RUN));

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONES_W'(RUN)); // R5
  AST_TAKE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_take |=> (ones_q == '0)); // R5
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int               STUFF_RUN = 5,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic [1:0]        fill_sel,
  input  logic              bit_en,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_eop,
  input  logic              fifo_abort,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic              tx_bit
);
  localparam int SH_W  = CRC_W;
  localparam int CNT_W = $clog2(SH_W + 1);

  tx_state_e        st_q, ld_st, cur_st;
  logic [SH_W-1:0]  sh_q, ld_sh, cur_sh;
  logic [CNT_W-1:0] cnt_q, ld_cnt, cur_cnt;
  logic             eop_q, tx_bit_q;
  logic             ld_take, ld_init;
  logic [CRC_W-1:0] crc_q;
  logic             stuff_req;

  // Named events for the checks and the helpers.
  logic stuffing_st, stuff_now, boundary, emit, out_bit, cur_stuffing;

  assign stuffing_st = (st_q == ST_DATA) || (st_q == ST_FCS);
  assign stuff_now   = bit_en && tx_enable && stuffing_st && stuff_req;
  assign boundary    = bit_en && tx_enable && !stuff_now && (cnt_q == '0);
  assign emit        = bit_en && tx_enable && !stuff_now;

  // Next unit chosen when the current one has run out.
  always_comb begin
    ld_st   = st_q;
    ld_sh   = sh_q;
    ld_cnt  = cnt_q;
    ld_take = 1'b0;
    ld_init = 1'b0;
    case (st_q)
      ST_OPEN, ST_DATA: begin
        if (st_q == ST_DATA && eop_q) begin
          ld_st  = ST_FCS;
          ld_sh  = ~crc_q;
          ld_cnt = CNT_W'(CRC_W);
        end else if (fifo_empty) begin
          ld_st  = ST_ABORT;
          ld_sh  = SH_W'(PAT_ONES);
          ld_cnt = CNT_W'(BYTE_W);
        end else begin
          ld_take = 1'b1;
          ld_cnt  = CNT_W'(BYTE_W);
          if (fifo_abort) begin
            ld_st = ST_ABORT;
            ld_sh = SH_W'(PAT_ONES);
          end else begin
            ld_st = ST_DATA;
            ld_sh = SH_W'(fifo_data);
          end
        end
      end
      ST_FCS: begin
        ld_st  = ST_CLOSE;
        ld_sh  = SH_W'(PAT_FLAG);
        ld_cnt = CNT_W'(BYTE_W);
      end
      default: begin
        ld_cnt = CNT_W'(BYTE_W);
        if (fill_sel != FILL_GOAHD && !fifo_empty) begin
          ld_st   = ST_OPEN;
          ld_sh   = SH_W'(PAT_FLAG);
          ld_init = 1'b1;
        end else begin
          ld_st = ST_FILL;
          ld_sh = SH_W'(fill_pattern(fill_sel));
        end
      end
    endcase
  end

  assign cur_st       = boundary ? ld_st  : st_q;
  assign cur_sh       = boundary ? ld_sh  : sh_q;
  assign cur_cnt      = boundary ? ld_cnt : cnt_q;
  assign out_bit      = cur_sh[0];
  assign cur_stuffing = (cur_st == ST_DATA) || (cur_st == ST_FCS);
  assign fifo_pop     = boundary && ld_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_FILL;
      sh_q     <= '0;
      cnt_q    <= '0;
      eop_q    <= 1'b0;
      tx_bit_q <= 1'b1;
    end else if (bit_en) begin
      if (!tx_enable) begin
        st_q     <= ST_FILL;
        cnt_q    <= '0;
        eop_q    <= 1'b0;
        tx_bit_q <= 1'b1;
      end else if (stuff_now) begin
        tx_bit_q <= 1'b0;
      end else begin
        tx_bit_q <= out_bit;
        sh_q     <= cur_sh >> 1;
        cnt_q    <= cur_cnt - 1'b1;
        st_q     <= cur_st;
        if (boundary && ld_init)                eop_q <= 1'b0;
        else if (boundary && ld_take && !fifo_abort) eop_q <= fifo_eop;
      end
    end
  end

  assign tx_bit = tx_bit_q;

  hdlc_fcs_gen #(.POLY(CRC_POLY)) u_fcs (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (boundary && ld_init),
    .shift (emit && cur_st == ST_DATA),
    .din   (out_bit),
    .crc_q (crc_q)
  );

  hdlc_zero_stuffer #(.RUN(STUFF_RUN)) u_stuff (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      ((emit && !cur_stuffing) || (bit_en && !tx_enable)),
    .advance    (emit && cur_stuffing),
    .bit_val    (out_bit),
    .stuff_take (stuff_now),
    .stuff_req  (stuff_req)
  );

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit)); // R2
  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |=> !tx_bit); // R5
  AST_GOAHEAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_sel == FILL_GOAHD && st_q != ST_OPEN && st_q != ST_DATA) |-> !fifo_pop); // R9
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !tx_enable) |=> tx_bit); // R10
  AST_NO_POP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> !fifo_pop); // R10
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty); // R11
endmodule

// File: tb/test_hdlc_tx_framer.sv
module test_hdlc_tx_framer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, tx_enable, bit_en;
  logic [1:0] fill_sel;
  logic [7:0] fifo_data;
  logic       fifo_eop, fifo_abort, fifo_empty;
  logic       fifo_pop, tx_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tx_framer i_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .fill_sel(fill_sel),
    .bit_en(bit_en), .fifo_data(fifo_data), .fifo_eop(fifo_eop),
    .fifo_abort(fifo_abort), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .tx_bit(tx_bit)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_tag = "R1";
  logic  exp_q[$];
  logic [9:0] fq[$];   // {abort, eop, data}
  int    m_ones;
  logic  en_seen = 1'b0, last_bit = 1'b1, mon_on = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    {fifo_abort, fifo_eop, fifo_data} = fifo_empty ? 10'h0 : fq[0];
  endtask

  // Bench FIFO: consumes on pop in the strobe cycle.
  always @(posedge clk) begin
    if (rst_n && fifo_pop) begin
      check(fq.size() != 0, "R11 pop while empty", 1, 0);
      if (fq.size() != 0) void'(fq.pop_front());
      #1 refresh();
    end
  end

  // Monitor: compare each strobed bit with the scoreboard queue.
  always @(posedge clk) en_seen <= bit_en;
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (en_seen) begin
        if (exp_q.size() == 0) check(0, {cur_tag, " extra bit"}, tx_bit, 0);
        else begin
          logic e;
          e = exp_q.pop_front();
          check(tx_bit === e, {cur_tag, " line bit"}, tx_bit, e);
        end
        last_bit = tx_bit;
      end else begin
        check(tx_bit === last_bit, "R2 hold between strobes", tx_bit, last_bit);
      end
    end
  end

  // Expected-stream model.
  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic push_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    m_ones = 0;
  endtask

  task automatic push_stuffed(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(b[i]);
      m_ones = b[i] ? m_ones + 1 : 0;
      if (m_ones == 5) begin exp_q.push_back(1'b0); m_ones = 0; end
    end
  endtask

  task automatic push_frame(input logic [7:0] bytes[$]);
    logic [15:0] c;
    c = 16'hFFFF;
    push_raw(8'h7E);
    foreach (bytes[i]) begin c = crc_byte(c, bytes[i]); push_stuffed(bytes[i]); end
    c = ~c;
    push_stuffed(c[7:0]);
    push_stuffed(c[15:8]);
    push_raw(8'h7E);
  endtask

  task automatic load(input logic abort_t, input logic eop_t, input logic [7:0] d);
    fq.push_back({abort_t, eop_t, d});
    refresh();
  endtask

  task automatic run_bits(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 bit_en = 1'b1;
      @(posedge clk); #1 bit_en = 1'b0;
      @(posedge clk); @(posedge clk);
    end
    @(posedge clk); #1;
  endtask

  task automatic run_expected();
    run_bits(exp_q.size());
    check(exp_q.size() == 0, {cur_tag, " stream complete"}, exp_q.size(), 0);
  endtask

  task automatic reset_dut(input logic [1:0] sel);
    mon_on = 1'b0;
    rst_n = 1'b0; bit_en = 1'b0; tx_enable = 1'b1; fill_sel = sel;
    fq.delete(); exp_q.delete(); refresh(); m_ones = 0;
    repeat (3) @(posedge clk);
    #2;
    check(tx_bit === 1'b1, "R1 reset tx_bit", tx_bit, 1);
    check(fifo_pop === 1'b0, "R1 reset pop", fifo_pop, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    last_bit = 1'b1; mon_on = 1'b1;
  endtask

  initial begin
    logic [7:0] fr[$];

    // R3: each fill encoding with an empty FIFO.
    reset_dut(2'b00); cur_tag = "R3 flag fill";
    repeat (3) push_raw(8'h7E); run_expected();
    reset_dut(2'b01); cur_tag = "R3 idle fill";
    repeat (3) push_raw(8'hFF); run_expected();
    reset_dut(2'b10); cur_tag = "R3 go-ahead fill";
    repeat (3) push_raw(8'h7F); run_expected();
    reset_dut(2'b11); cur_tag = "R3 reserved fill";
    repeat (3) push_raw(8'h7E); run_expected();

    // R4 R5 R6: full frame with a stuffing-heavy payload.
    reset_dut(2'b00); cur_tag = "R4 R5 R6 frame";
    load(0, 0, 8'h12); load(0, 0, 8'hFF); load(0, 1, 8'h3E);
    fr = '{8'h12, 8'hFF, 8'h3E}; push_frame(fr);
    repeat (2) push_raw(8'h7E);
    run_expected();
    check(fq.size() == 0, "R4 all bytes popped", fq.size(), 0);

    // R7: underrun after two bytes without end-of-packet.
    reset_dut(2'b00); cur_tag = "R7 underrun";
    load(0, 0, 8'hA5); load(0, 0, 8'hF8);
    push_raw(8'h7E); push_stuffed(8'hA5); push_stuffed(8'hF8);
    push_raw(8'hFF); repeat (2) push_raw(8'h7E);
    run_expected();

    // R8: abort-tagged byte replaced, then a new frame.
    reset_dut(2'b01); cur_tag = "R8 abort tag";
    load(0, 0, 8'h55); load(1, 0, 8'h00); load(0, 1, 8'h81);
    push_raw(8'h7E); push_stuffed(8'h55); push_raw(8'hFF);
    fr = '{8'h81}; push_frame(fr);
    repeat (2) push_raw(8'hFF);
    run_expected();
    check(fq.size() == 0, "R8 tagged byte consumed", fq.size(), 0);

    // R9: go-ahead holds data off until the select changes.
    reset_dut(2'b10); cur_tag = "R9 go-ahead hold";
    load(0, 1, 8'h11);
    repeat (5) push_raw(8'h7F); run_expected();
    check(fq.size() == 1, "R9 no pop during go-ahead", fq.size(), 1);
    fill_sel = 2'b00; cur_tag = "R9 release";
    fr = '{8'h11}; push_frame(fr); push_raw(8'h7E);
    run_expected();
    check(fq.size() == 0, "R9 byte sent after release", fq.size(), 0);

    // R10: disable mid-frame.
    reset_dut(2'b00); cur_tag = "R10 before disable";
    load(0, 0, 8'hF0); load(0, 0, 8'h0F);
    push_raw(8'h7E); repeat (4) exp_q.push_back(1'b0);
    run_expected();
    tx_enable = 1'b0; cur_tag = "R10 disabled ones";
    repeat (8) exp_q.push_back(1'b1);
    run_expected();
    check(fq.size() == 1, "R10 no pop while disabled", fq.size(), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule